// File: doc/BRIEF.md
# Debug Data Channel Handshake

This block sits between an external debugger and a processor core. It holds three registers: a receive data register that carries words from the debugger to the core, a transmit data register that carries words from the core to the debugger, and an instruction register that the debugger loads for the core. Each of the three paths has a live ready flag and a shadow copy of that flag, called the latched flag.

The debugger's port makes its accept-or-drop decisions from the latched flags only. A debugger write or read that finds its latched flag not ready is dropped without any indication. The latched flags take the values of the live flags each time the debugger reads the status word. Outside a status read, a latched flag changes only when a debugger access is accepted.

The core's port reads receive data, writes transmit data and pulses completion of an instruction. These actions change only the live flags. A two-bit access-mode field can be written from the debugger side. It is reported in the status word, but every value of it gives non-blocking behaviour.

Top module: `dbg_chan`

## Requirements
- R1: After reset, the live and latched receive-full flags are 0, the live and latched transmit-full flags are 0, the live and latched instruction-complete flags are 1, and the mode field is 00. The status word therefore reads 0x10.
- R2: A debugger write to receive data while the latched receive-full flag is 0 loads `ext_wdata` into `core_rx_data`. At the next edge it sets both the live and the latched receive-full flags.
- R3: A debugger write to receive data while the latched receive-full flag is 1 is dropped. This holds even when the live flag is already 0. `core_rx_data` and the flags stay unchanged.
- R4: A debugger read of transmit data while the latched transmit-full flag is 1 returns the transmit register on `ext_rdata` in the same cycle. At the next edge it clears both the latched and the live transmit-full flags.
- R5: A debugger read of transmit data while the latched transmit-full flag is 0 is dropped. This holds even when the live flag is 1. `ext_rdata` reads zero and the flags stay unchanged.
- R6: A debugger write to the instruction register while the latched instruction-complete flag is 1 loads `ir_data`. At the next edge it clears both the live and the latched instruction-complete flags.
- R7: A debugger write to the instruction register while the latched instruction-complete flag is 0 is dropped, and `ir_data` keeps its value.
- R8: A status read copies every live flag into its latched flag at the next edge. When an access is accepted in the same cycle, the accepted access decides its own flag. Core-side actions never change a latched flag, and a latched flag copied during a status read takes the live value from before that cycle's core actions.
- R9: A core read of receive data clears the live receive-full flag. A core write of transmit data loads the transmit register and sets the live transmit-full flag. A completion pulse sets the live instruction-complete flag. When a set and a clear reach the same live flag in the same cycle, the set wins.
- R10: `ext_mode_wr` loads the mode field. The mode values 01, 10 and 11 accept and drop debugger accesses exactly as 00 does, and the mode field has no effect on the core port.
- R11: The status word has the following bit layout: bit 0 live receive-full, bit 1 live transmit-full, bit 2 latched receive-full, bit 3 latched transmit-full, bit 4 latched instruction-complete, bits 6:5 mode. The live instruction-complete flag does not appear in the status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_rx_wr | input | 1 | Debugger write to receive data |
| ext_ir_wr | input | 1 | Debugger write to instruction register |
| ext_wdata | input | DW | Debugger write data |
| ext_tx_rd | input | 1 | Debugger read of transmit data |
| ext_rdata | output | DW | Transmit data returned to debugger, zero when the read is dropped |
| ext_stat_rd | input | 1 | Debugger status read; refreshes the latched flags |
| ext_mode_wr | input | 1 | Debugger write of the mode field |
| ext_mode_wdata | input | 2 | New mode value |
| status | output | 7 | Status word |
| core_rx_rd | input | 1 | Core read of receive data |
| core_rx_data | output | DW | Receive data register |
| core_rx_full | output | 1 | Live receive-full flag |
| core_tx_wr | input | 1 | Core write of transmit data |
| core_tx_wdata | input | DW | Core transmit data |
| core_tx_full | output | 1 | Live transmit-full flag |
| core_done | input | 1 | Instruction completion pulse |
| ir_data | output | DW | Instruction register |

## Verification
The bound checker covers the following on every cycle: each accepted access and its effect on its flags, each dropped access leaving its data register unchanged, the latched flags holding still when there is no debugger activity, the core-side set and clear actions, and the mode-field write. The bench scenarios are needed to show the cases that rely on the latched and live flags disagreeing. These are a receive write dropped after the core has already emptied the register, a transmit read dropped while the live flag is set, and a completion that only becomes visible after a status read. The scenarios also cover a status read in the same cycle as a core action, and the set-over-clear outcomes under the non-default mode values.

// File: rtl/dbg_chan.sv
module dbg_chan #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ext_rx_wr,
  input  logic          ext_ir_wr,
  input  logic [DW-1:0] ext_wdata,
  input  logic          ext_tx_rd,
  output logic [DW-1:0] ext_rdata,
  input  logic          ext_stat_rd,
  input  logic          ext_mode_wr,
  input  logic [1:0]    ext_mode_wdata,
  output logic [6:0]    status,
  input  logic          core_rx_rd,
  output logic [DW-1:0] core_rx_data,
  output logic          core_rx_full,
  input  logic          core_tx_wr,
  input  logic [DW-1:0] core_tx_wdata,
  output logic          core_tx_full,
  input  logic          core_done,
  output logic [DW-1:0] ir_data
);

  logic [1:0]    mode;
  logic [DW-1:0] rx_q, tx_q, ir_q;
  logic          rx_f, tx_f, ic_f;
  logic          rx_l, tx_l, ic_l;
  logic          rx_ok, tx_ok, ir_ok;

  assign rx_ok = ext_rx_wr & ~rx_l;
  assign tx_ok = ext_tx_rd &  tx_l;
  assign ir_ok = ext_ir_wr &  ic_l;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode <= 2'b00;
      rx_q <= '0;
      tx_q <= '0;
      ir_q <= '0;
      rx_f <= 1'b0;
      tx_f <= 1'b0;
      ic_f <= 1'b1;
      rx_l <= 1'b0;
      tx_l <= 1'b0;
      ic_l <= 1'b1;
    end else begin
      if (ext_mode_wr) mode <= ext_mode_wdata;
      if (rx_ok)       rx_q <= ext_wdata;
      if (core_tx_wr)  tx_q <= core_tx_wdata;
      if (ir_ok)       ir_q <= ext_wdata;

      if (rx_ok)           rx_f <= 1'b1;
      else if (core_rx_rd) rx_f <= 1'b0;
      if (core_tx_wr)      tx_f <= 1'b1;
      else if (tx_ok)      tx_f <= 1'b0;
      if (core_done)       ic_f <= 1'b1;
      else if (ir_ok)      ic_f <= 1'b0;

      if (rx_ok)            rx_l <= 1'b1;
      else if (ext_stat_rd) rx_l <= rx_f;
      if (tx_ok)            tx_l <= 1'b0;
      else if (ext_stat_rd) tx_l <= tx_f;
      if (ir_ok)            ic_l <= 1'b0;
      else if (ext_stat_rd) ic_l <= ic_f;
    end
  end

  assign ext_rdata    = tx_ok ? tx_q : '0;
  assign status       = {mode, ic_l, tx_l, rx_l, tx_f, rx_f};
  assign core_rx_data = rx_q;
  assign core_rx_full = rx_f;
  assign core_tx_full = tx_f;
  assign ir_data      = ir_q;

endmodule

// File: rtl/dbg_chan_chk.sv
module dbg_chan_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ext_rx_wr,
  input logic          ext_ir_wr,
  input logic [DW-1:0] ext_wdata,
  input logic          ext_tx_rd,
  input logic [DW-1:0] ext_rdata,
  input logic          ext_stat_rd,
  input logic          ext_mode_wr,
  input logic [1:0]    ext_mode_wdata,
  input logic [6:0]    status,
  input logic          core_rx_rd,
  input logic [DW-1:0] core_rx_data,
  input logic          core_tx_wr,
  input logic [DW-1:0] ir_data
);

  AST_RX_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    ext_rx_wr && !status[2] |=> status[0] && status[2] && core_rx_data == $past(ext_wdata)); // R2
  AST_RX_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    ext_rx_wr && status[2] |=> $stable(core_rx_data)); // R3
  AST_TX_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    ext_tx_rd && status[3] && !core_tx_wr |=> !status[1] && !status[3]); // R4
  AST_TX_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    ext_tx_rd && !status[3] |-> ext_rdata == '0); // R5
  AST_IR_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    ext_ir_wr && status[4] |=> !status[4] && ir_data == $past(ext_wdata)); // R6
  AST_IR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    ext_ir_wr && !status[4] && !ext_stat_rd |=> $stable(ir_data) && !status[4]); // R7
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_stat_rd && !ext_rx_wr && !ext_tx_rd && !ext_ir_wr |=> $stable(status[4:2])); // R8
  AST_CORE_RX_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    core_rx_rd && !ext_rx_wr |=> !status[0]); // R9
  AST_CORE_TX_SET: assert property (@(posedge clk) disable iff (!rst_n)
    core_tx_wr |=> status[1]); // R9
  AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ext_mode_wr |=> status[6:5] == $past(ext_mode_wdata)); // R10

endmodule

bind dbg_chan dbg_chan_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ext_rx_wr(ext_rx_wr), .ext_ir_wr(ext_ir_wr),
  .ext_wdata(ext_wdata), .ext_tx_rd(ext_tx_rd), .ext_rdata(ext_rdata),
  .ext_stat_rd(ext_stat_rd), .ext_mode_wr(ext_mode_wr),
  .ext_mode_wdata(ext_mode_wdata), .status(status), .core_rx_rd(core_rx_rd),
  .core_rx_data(core_rx_data), .core_tx_wr(core_tx_wr), .ir_data(ir_data)
);

// File: tb/dbg_chan_test.sv
module dbg_chan_test;
  localparam int CLK_P = 10;
  localparam int DW = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ext_rx_wr = 0, ext_ir_wr = 0, ext_tx_rd = 0, ext_stat_rd = 0, ext_mode_wr = 0;
  logic [DW-1:0] ext_wdata = '0, core_tx_wdata = '0;
  logic [1:0] ext_mode_wdata = '0;
  logic core_rx_rd = 0, core_tx_wr = 0, core_done = 0;
  logic [DW-1:0] ext_rdata, core_rx_data, ir_data;
  logic [6:0] status;
  logic core_rx_full, core_tx_full;

  always #(CLK_P/2) clk = ~clk;

  dbg_chan #(.DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .ext_rx_wr(ext_rx_wr), .ext_ir_wr(ext_ir_wr),
    .ext_wdata(ext_wdata), .ext_tx_rd(ext_tx_rd), .ext_rdata(ext_rdata),
    .ext_stat_rd(ext_stat_rd), .ext_mode_wr(ext_mode_wr), .ext_mode_wdata(ext_mode_wdata),
    .status(status), .core_rx_rd(core_rx_rd), .core_rx_data(core_rx_data),
    .core_rx_full(core_rx_full), .core_tx_wr(core_tx_wr), .core_tx_wdata(core_tx_wdata),
    .core_tx_full(core_tx_full), .core_done(core_done), .ir_data(ir_data)
  );

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sb[$];
  int checks = 0, errors = 0;
  bit finished = 0;

  localparam int K_STAT = 0, K_RXD = 1, K_IRD = 2, K_RDATA = 3, K_FLAGS = 4;

  task automatic expect_item(input int kind, input logic [31:0] exp, input string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic tick();
    @(negedge clk);
    ext_rx_wr = 0; ext_ir_wr = 0; ext_tx_rd = 0; ext_stat_rd = 0; ext_mode_wr = 0;
    core_rx_rd = 0; core_tx_wr = 0; core_done = 0;
  endtask

  always begin
    @(negedge clk);
    #(CLK_P/4);
    while (sb.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sb.pop_front();
      case (it.kind)
        K_STAT:  act = 32'(status);
        K_RXD:   act = core_rx_data;
        K_IRD:   act = ir_data;
        K_RDATA: act = ext_rdata;
        default: act = {30'd0, core_tx_full, core_rx_full};
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s actual=0x%0h expected=0x%0h", it.tag, act, it.exp);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    expect_item(K_STAT, 32'h10, "R1 reset status");
    expect_item(K_FLAGS, 32'h0, "R1 reset core flags");
    tick();

    ext_rx_wr = 1; ext_wdata = 32'hA5A5_0001; tick();
    expect_item(K_STAT, 32'h15, "R2 rx accepted flags");
    expect_item(K_RXD, 32'hA5A5_0001, "R2 rx data");
    ext_rx_wr = 1; ext_wdata = 32'h2222; tick();
    expect_item(K_RXD, 32'hA5A5_0001, "R3 rx dropped when full");
    expect_item(K_STAT, 32'h15, "R3 flags unchanged");
    core_rx_rd = 1; tick();
    expect_item(K_STAT, 32'h14, "R9 core read clears live only (R8)");
    ext_rx_wr = 1; ext_wdata = 32'h3333; tick();
    expect_item(K_RXD, 32'hA5A5_0001, "R3 dropped on stale latched flag");
    ext_stat_rd = 1; tick();
    expect_item(K_STAT, 32'h10, "R8 refresh rx latched");
    ext_rx_wr = 1; ext_wdata = 32'h4444; tick();
    expect_item(K_STAT, 32'h15, "R2 second rx");
    expect_item(K_RXD, 32'h4444, "R2 second rx data");

    ext_tx_rd = 1; expect_item(K_RDATA, 32'h0, "R5 tx read empty returns zero"); tick();
    expect_item(K_STAT, 32'h15, "R5 flags unchanged");
    core_tx_wr = 1; core_tx_wdata = 32'hBEEF; tick();
    expect_item(K_STAT, 32'h17, "R9 core tx sets live");
    expect_item(K_FLAGS, 32'h3, "R9 core flags");
    ext_tx_rd = 1; expect_item(K_RDATA, 32'h0, "R5 dropped while live full"); tick();
    expect_item(K_STAT, 32'h17, "R5 stale latched unchanged");
    ext_stat_rd = 1; tick();
    expect_item(K_STAT, 32'h1F, "R8 refresh all latched (R11)");
    ext_tx_rd = 1; expect_item(K_RDATA, 32'hBEEF, "R4 tx read data"); tick();
    expect_item(K_STAT, 32'h15, "R4 tx flags cleared");

    ext_ir_wr = 1; ext_wdata = 32'h11; tick();
    expect_item(K_IRD, 32'h11, "R6 ir loaded");
    expect_item(K_STAT, 32'h05, "R6 ic latched cleared");
    ext_ir_wr = 1; ext_wdata = 32'h22; tick();
    expect_item(K_IRD, 32'h11, "R7 ir dropped");
    core_done = 1; tick();
    expect_item(K_STAT, 32'h05, "R8 done invisible until refresh");
    ext_ir_wr = 1; ext_wdata = 32'h33; tick();
    expect_item(K_IRD, 32'h11, "R7 dropped with stale latched");
    ext_stat_rd = 1; tick();
    expect_item(K_STAT, 32'h15, "R8 ic latched refreshed");
    ext_ir_wr = 1; ext_wdata = 32'h44; tick();
    expect_item(K_IRD, 32'h44, "R6 ir accepted after refresh");
    expect_item(K_STAT, 32'h05, "R6 flags");

    ext_mode_wr = 1; ext_mode_wdata = 2'b01; tick();
    expect_item(K_STAT, 32'h25, "R10 mode 01 in status");
    ext_rx_wr = 1; ext_wdata = 32'h55; tick();
    expect_item(K_RXD, 32'h4444, "R10 mode 01 drops like non-blocking");
    core_rx_rd = 1; tick();
    expect_item(K_STAT, 32'h24, "R10 core port unaffected by mode");
    ext_stat_rd = 1; tick();
    expect_item(K_STAT, 32'h20, "R8 refresh in mode 01");
    ext_rx_wr = 1; ext_wdata = 32'h66; tick();
    expect_item(K_RXD, 32'h66, "R10 mode 01 accepts");
    ext_mode_wr = 1; ext_mode_wdata = 2'b11; tick();
    expect_item(K_STAT, 32'h65, "R10 mode 11 in status");
    ext_ir_wr = 1; ext_wdata = 32'h77; tick();
    expect_item(K_IRD, 32'h44, "R10 mode 11 ir dropped");

    ext_stat_rd = 1; core_rx_rd = 1; tick();
    expect_item(K_STAT, 32'h64, "R8 refresh takes pre-core live value");
    ext_stat_rd = 1; tick();
    expect_item(K_STAT, 32'h60, "R8 refresh");
    ext_rx_wr = 1; ext_wdata = 32'h88; core_rx_rd = 1; tick();
    expect_item(K_STAT, 32'h65, "R9 set wins over core clear");
    expect_item(K_RXD, 32'h88, "R2 data with concurrent core read");
    core_tx_wr = 1; core_tx_wdata = 32'h99; tick();
    ext_stat_rd = 1; tick();
    expect_item(K_STAT, 32'h6F, "R8 refresh tx, ic latched stays 0");
    ext_tx_rd = 1; core_tx_wr = 1; core_tx_wdata = 32'hAA;
    expect_item(K_RDATA, 32'h99, "R4 read with concurrent core write"); tick();
    expect_item(K_STAT, 32'h67, "R9 live set wins, latched cleared");
    ext_tx_rd = 1; expect_item(K_RDATA, 32'h0, "R5 dropped after clear"); tick();

    tick();
    tick();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule